// File: doc/BRIEF.md
# Water-Filling Bank Write Selector

This block picks the slow memory bank that stores each arriving fixed-size packet in a buffer whose packets leave at known times. Time advances in slots, and at most one packet arrives per slot. The departure time of the arriving packet fixes the memory block, which is one row of an occupancy table. A memory block covers the departures of a span of N frames, and a frame is B slots. Each cell of the table counts the packets that one bank holds for that memory block, and it never goes above N.

In each slot the block forms a candidate vector with one bit per bank. A bank is excluded if it is still finishing one of its own recent writes, or if the read scheduler has flagged it for a read. Among the candidates the block grants the bank whose section in the target row is emptiest. When the bank count is at least 3B-1, some bank is always free. On a grant, the occupancy count of the chosen bank goes up by one and the bank is held busy. A separate clear port empties a section once it has been drained toward departure.

Top module: `wf_bank_select`

## Requirements
- R1: After reset every occupancy count is zero and no bank is held busy by a write, so with no reads flagged all bits of `cand_vec` are 1 and `grant` is 0 while `arr_valid` is 0.
- R2: The target row is `(arr_dep_time / (B*N)) mod M` and is shown on `sel_row`.
- R3: `sel_count` shows the count that the selected bank holds in the target row before the write. No count ever exceeds N.
- R4: Bit k of `cand_vec` is 1 exactly when bit k of `rd_busy` is 0 and bank k was not granted in any of the previous B-1 slots.
- R5: `sel_bank` is the candidate with the smallest count in the target row. On a tie, the lowest bank index wins.
- R6: `grant` is 1 when `arr_valid` is 1, at least one candidate exists and the selected section holds fewer than N packets. With K >= 3B-1 and at most B bits of `rd_busy` set, every arrival finds a candidate.
- R7: After a grant, the count of the granted bank in the target row is one higher in the next slot. The bank is then not a candidate for the next B-1 slots.
- R8: When the selected section already holds N packets, `grant` is 0, `ovf_err` is 1 and no count changes. `ovf_err` is 0 in every other case.
- R9: A clear request (`clr_valid`, `clr_row`, `clr_bank`) sets that count to zero at the end of the slot. An increment to the same cell in the same slot is applied after the clear.
- R10: A slot with `arr_valid` at 0 grants nothing, flags no overflow and leaves every count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arr_valid | input | 1 | A packet arrives in this slot |
| arr_dep_time | input | TIME_W | Departure slot of the arriving packet |
| rd_busy | input | K | Banks reserved for scheduled reads in this slot |
| clr_valid | input | 1 | Clear one section count |
| clr_row | input | ROW_W | Row of the section to clear |
| clr_bank | input | BANK_W | Bank of the section to clear |
| grant | output | 1 | The arrival is written to `sel_bank` |
| ovf_err | output | 1 | The selected section is full, so the write is refused |
| sel_bank | output | BANK_W | Chosen bank |
| sel_row | output | ROW_W | Target memory block row |
| sel_count | output | CNT_W | Count of the chosen section before the write |
| cand_vec | output | K | Write-candidate vector |

## Verification
A short burst of arrivals into one empty row separates least-full selection from plain rotation. Because every count starts equal, the lowest-index tie rule and the B-1 slot write hold decide the order in which banks are chosen. Fixed read masks with different departure times show that reads exclude banks and that the row wraps modulo M. A fully masked slot shows that no grant is given when no candidate exists. Filling one row until it overflows, and then clearing one section, covers the refusal path and the clear-before-increment order. A long pseudo-random run follows, with at most B read bits set and random clears, to test the guarantee that every arrival finds a bank.

// File: rtl/wf_sel_pkg.sv
package wf_sel_pkg;
  localparam int DEF_BANKS  = 8;
  localparam int DEF_SLOT_B = 3;
  localparam int DEF_SECT_N = 4;
  localparam int DEF_ROWS   = 4;
  localparam int DEF_TIME_W = 16;

  // memory block row owning a departure slot: span of n frames of b slots
  function automatic int unsigned block_row(int unsigned dep, int unsigned b,
                                            int unsigned n, int unsigned m);
    return (dep / (b * n)) % m;
  endfunction
endpackage

// File: rtl/wf_busy_track.sv
module wf_busy_track #(
  parameter int K = 8,
  parameter int B = 3,
  localparam int BANK_W = $clog2(K),
  localparam int HOLD_W = $clog2(B + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [K-1:0]      wr_busy
);
  for (genvar g = 0; g < K; g++) begin : g_bank
    logic [HOLD_W-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  hold_q <= '0;
      else if (wr_en && wr_bank == BANK_W'(g))     hold_q <= HOLD_W'(B - 1);
      else if (hold_q != '0)                       hold_q <= hold_q - 1'b1;
    end
    assign wr_busy[g] = (hold_q != '0);
  end
endmodule

// File: rtl/wf_min_pick.sv
module wf_min_pick #(
  parameter int K = 8,
  parameter int CNT_W = 3,
  localparam int BANK_W = $clog2(K)
) (
  input  logic [K-1:0]            cand,
  input  logic [K-1:0][CNT_W-1:0] cnts,
  output logic                    found,
  output logic [BANK_W-1:0]       idx,
  output logic [CNT_W-1:0]        min_cnt
);
  always_comb begin
    found   = 1'b0;
    idx     = '0;
    min_cnt = '0;
    for (int k = 0; k < K; k++) begin
      // strict compare keeps the lowest index on a tie
      if (cand[k] && (!found || cnts[k] < min_cnt)) begin
        found   = 1'b1;
        idx     = BANK_W'(k);
        min_cnt = cnts[k];
      end
    end
  end
endmodule

// File: rtl/wf_occ_table.sv
module wf_occ_table #(
  parameter int K = 8,
  parameter int M = 4,
  parameter int N = 4,
  localparam int BANK_W = $clog2(K),
  localparam int ROW_W  = $clog2(M),
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ROW_W-1:0]        rd_row,
  output logic [K-1:0][CNT_W-1:0] row_cnts,
  input  logic                    inc_en,
  input  logic [ROW_W-1:0]        inc_row,
  input  logic [BANK_W-1:0]       inc_bank,
  input  logic                    clr_en,
  input  logic [ROW_W-1:0]        clr_row,
  input  logic [BANK_W-1:0]       clr_bank
);
  logic [CNT_W-1:0] occ [M][K];

  for (genvar r = 0; r < M; r++) begin : g_row
    for (genvar k = 0; k < K; k++) begin : g_col
      logic inc_hit, clr_hit;
      assign inc_hit = inc_en && inc_row == ROW_W'(r) && inc_bank == BANK_W'(k);
      assign clr_hit = clr_en && clr_row == ROW_W'(r) && clr_bank == BANK_W'(k);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       occ[r][k] <= '0;
        else if (inc_hit) occ[r][k] <= (clr_hit ? '0 : occ[r][k]) + 1'b1;
        else if (clr_hit) occ[r][k] <= '0;
      end
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_read
    assign row_cnts[k] = occ[rd_row][k];
  end
endmodule

// File: rtl/wf_bank_select.sv
module wf_bank_select
  import wf_sel_pkg::*;
#(
  parameter int K      = DEF_BANKS,
  parameter int B      = DEF_SLOT_B,
  parameter int N      = DEF_SECT_N,
  parameter int M      = DEF_ROWS,
  parameter int TIME_W = DEF_TIME_W,
  localparam int BANK_W = $clog2(K),
  localparam int ROW_W  = $clog2(M),
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [TIME_W-1:0] arr_dep_time,
  input  logic [K-1:0]      rd_busy,
  input  logic              clr_valid,
  input  logic [ROW_W-1:0]  clr_row,
  input  logic [BANK_W-1:0] clr_bank,
  output logic              grant,
  output logic              ovf_err,
  output logic [BANK_W-1:0] sel_bank,
  output logic [ROW_W-1:0]  sel_row,
  output logic [CNT_W-1:0]  sel_count,
  output logic [K-1:0]      cand_vec
);
  logic [K-1:0]            wr_busy;
  logic [K-1:0][CNT_W-1:0] row_cnts;
  logic                    pick_found;
  logic                    pick_full;
  logic                    wr_fire;

  assign sel_row  = ROW_W'(block_row(32'(arr_dep_time), B, N, M));
  assign cand_vec = ~rd_busy & ~wr_busy;

  wf_occ_table #(.K(K), .M(M), .N(N)) u_occ (
    .clk, .rst_n,
    .rd_row   (sel_row),
    .row_cnts (row_cnts),
    .inc_en   (wr_fire),
    .inc_row  (sel_row),
    .inc_bank (sel_bank),
    .clr_en   (clr_valid),
    .clr_row  (clr_row),
    .clr_bank (clr_bank)
  );

  wf_min_pick #(.K(K), .CNT_W(CNT_W)) u_pick (
    .cand    (cand_vec),
    .cnts    (row_cnts),
    .found   (pick_found),
    .idx     (sel_bank),
    .min_cnt (sel_count)
  );

  wf_busy_track #(.K(K), .B(B)) u_busy (
    .clk, .rst_n,
    .wr_en   (wr_fire),
    .wr_bank (sel_bank),
    .wr_busy (wr_busy)
  );

  assign pick_full = (sel_count == CNT_W'(N));
  assign wr_fire   = arr_valid && pick_found && !pick_full;
  assign grant     = wr_fire;
  assign ovf_err   = arr_valid && pick_found && pick_full;
endmodule

// File: rtl/wf_bank_select_chk.sv
module wf_bank_select_chk #(
  parameter int K = 8,
  parameter int B = 3,
  parameter int N = 4,
  localparam int BANK_W = $clog2(K),
  localparam int CNT_W  = $clog2(N + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    arr_valid,
  input logic [K-1:0]            rd_busy,
  input logic [K-1:0]            cand_vec,
  input logic                    grant,
  input logic                    ovf_err,
  input logic [BANK_W-1:0]       sel_bank,
  input logic [CNT_W-1:0]        sel_count,
  input logic [K-1:0][CNT_W-1:0] row_cnts
);
  logic min_ok;
  always_comb begin
    min_ok = 1'b1;
    for (int k = 0; k < K; k++) begin
      if (cand_vec[k] && row_cnts[k] < sel_count) min_ok = 1'b0;
      if (cand_vec[k] && row_cnts[k] == sel_count && BANK_W'(k) < sel_bank) min_ok = 1'b0;
    end
  end

  assert_reads_excluded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vec & rd_busy) == '0);
  assert_hold_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !cand_vec[$past(sel_bank)]);
  assert_pick_is_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || ovf_err) |-> cand_vec[sel_bank]);
  assert_least_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || ovf_err) |-> min_ok);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_count <= CNT_W'(N));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && ovf_err));
  assert_always_admit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && $countones(rd_busy) <= B) |-> (cand_vec != '0));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |-> !grant && !ovf_err);
endmodule

bind wf_bank_select wf_bank_select_chk #(.K(K), .B(B), .N(N)) u_chk (
  .clk, .rst_n, .arr_valid, .rd_busy, .cand_vec, .grant, .ovf_err,
  .sel_bank, .sel_count, .row_cnts
);

// File: tb/tb_wf_bank_select.sv
module tb_wf_bank_select;
  localparam int K = 8, B = 3, N = 4, M = 4, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arr_valid = 1'b0, clr_valid = 1'b0;
  logic [TW-1:0] arr_dep_time = '0;
  logic [K-1:0] rd_busy = '0;
  logic [1:0] clr_row = '0;
  logic [2:0] clr_bank = '0;
  logic grant, ovf_err;
  logic [2:0] sel_bank;
  logic [1:0] sel_row;
  logic [2:0] sel_count;
  logic [K-1:0] cand_vec;

  always #2 clk = ~clk;

  wf_bank_select dut (.*);

  int n_chk = 0, n_err = 0;
  int occ [M][K];
  int hold [K];

  typedef struct {
    bit v; bit g; bit o; int bank; int row; int cnt; logic [K-1:0] cand;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one slot and pushes the expected outcome
  task automatic slot(bit v, int dep, logic [K-1:0] rd, bit c, int crow, int cbank);
    exp_t e;
    bit found; int best;
    @(negedge clk);
    arr_valid = v; arr_dep_time = TW'(dep); rd_busy = rd;
    clr_valid = c; clr_row = 2'(crow); clr_bank = 3'(cbank);
    e.v = v;
    e.row = (dep / (B * N)) % M;
    found = 0; best = 0;
    for (int k = 0; k < K; k++) begin
      e.cand[k] = !rd[k] && hold[k] == 0;
      if (e.cand[k] && (!found || occ[e.row][k] < occ[e.row][best])) begin
        found = 1; best = k;
      end
    end
    e.bank = best;
    e.cnt  = occ[e.row][best];
    e.g = v && found && e.cnt < N;
    e.o = v && found && e.cnt == N;
    exp_q.push_back(e);
    for (int k = 0; k < K; k++) if (hold[k] > 0) hold[k]--;
    if (c) occ[crow][cbank] = 0;
    if (e.g) begin occ[e.row][best]++; hold[best] = B - 1; end
  endtask

  // monitor: compares between edges
  initial begin
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cand_vec == e.cand, "R4", "cand_vec", int'(cand_vec), int'(e.cand));
        chk(grant == e.g, "R6", "grant", int'(grant), int'(e.g));
        chk(ovf_err == e.o, "R8", "ovf_err", int'(ovf_err), int'(e.o));
        if (e.v) chk(int'(sel_row) == e.row, "R2", "sel_row", int'(sel_row), e.row);
        if (e.g || e.o) begin
          chk(int'(sel_bank) == e.bank, "R5", "sel_bank", int'(sel_bank), e.bank);
          chk(int'(sel_count) == e.cnt, "R3_R7_R9", "sel_count", int'(sel_count), e.cnt);
        end
      end
    end
  end

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < M; r++) for (int k = 0; k < K; k++) occ[r][k] = 0;
    for (int k = 0; k < K; k++) hold[k] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cand_vec == '1, "R1", "cand_vec after reset", int'(cand_vec), 255);
    chk(grant == 1'b0, "R1", "grant after reset", int'(grant), 0);

    // R5 R7: burst into one empty row
    for (int i = 0; i < 6; i++) slot(1, 5, '0, 0, 0, 0);
    // R4 R2: read masks, rows including wrap
    slot(1, 12, 8'b0000_0111, 0, 0, 0);
    slot(1, 24, 8'b1110_0000, 0, 0, 0);
    slot(1, 36, 8'b0101_0101, 0, 0, 0);
    slot(1, 48, 8'b0001_1000, 0, 0, 0);
    // R6 no candidate at all
    slot(1, 7, 8'hFF, 0, 0, 0);
    // R10 idle slots
    slot(0, 0, '0, 0, 0, 0);
    slot(0, 30, '0, 0, 0, 0);
    // R8: fill row 2 and overflow
    for (int i = 0; i < 40; i++) slot(1, 25, '0, 0, 0, 0);
    // R9: clear one section then refill it
    slot(0, 0, '0, 1, 2, 3);
    slot(1, 26, '0, 0, 0, 0);
    slot(0, 0, '0, 0, 0, 0);
    slot(0, 0, '0, 0, 0, 0);
    // R9 clear and arrival in same slot
    slot(1, 26, '0, 1, 2, 3);
    slot(1, 26, '0, 1, 2, 5);
    slot(1, 26, '0, 0, 0, 0);
    // R6 guarantee: random traffic, at most B reads flagged
    for (int i = 0; i < 400; i++) begin
      logic [K-1:0] rd;
      rd = '0;
      for (int j = 0; j < B; j++) if ($urandom_range(1, 0) == 1) rd[$urandom_range(K - 1, 0)] = 1'b1;
      slot($urandom_range(3, 0) != 0, int'($urandom_range(200, 0)), rd,
           $urandom_range(1, 0) == 1, int'($urandom_range(M - 1, 0)), int'($urandom_range(K - 1, 0)));
    end
    slot(0, 0, '0, 0, 0, 0);
    @(negedge clk); #2;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule